// File: doc/BRIEF.md
# Carrier Cycle Counter with Snapshot

This block measures integrated carrier phase for one tracking channel. A carrier NCO is modelled as an `ACC_W`-bit phase accumulator that adds a programmable increment word every clock. Each carry out of that addition marks one completed carrier cycle, and a 20-bit cycle counter advances by one.

A periodic measurement strobe (`tic`) does two things in order. It first freezes the running count into a 4-bit high register and a 16-bit low register, together with the top `PH_W` bits of the accumulator, which give the cycle fraction. It then clears the counter for the next interval. At the nominal rate of about 1.405 MHz, a 100 ms interval holds roughly 140540 cycles, which fits in 20 bits.

Software reads the snapshot through a small read port and has to do so before the next strobe. In test mode, software can preload the counter through a per-channel address, a masked multi-channel alias or an all-channels alias.

Top module: `carrier_cycle_meter`

## Requirements
- R1: Each carry out of the `ACC_W`-bit addition `acc + phase_inc` advances the cycle counter by exactly one, wrapping modulo 2^20. The accumulator itself wraps modulo 2^ACC_W.
- R2: When `tic` is high at a clock edge, `cyc_hi` takes counter bits 19:16 and `cyc_lo` takes bits 15:0 as they stood before that edge. The counter is then cleared.
- R3: On the same `tic` edge, `phase_snap` takes the top `PH_W` bits of the accumulator value held before that edge.
- R4: An accumulator carry in the same cycle as `tic` is not part of the snapshot. It counts as the first cycle of the new interval, so the counter becomes 1.
- R5: In test mode, a write to the counter address loads `wr_data` into counter bits 15:0 and clears bits 19:16. Such a write takes priority over a clear or an increment in the same cycle.
- R6: With `test_mode` low, writes to the counter address leave the counter unchanged.
- R7: Three addresses reach the counter write. The per-channel address is `CH_BASE+0x08`. The multi-channel alias `0x188` takes effect only when `chan_mask[CHAN_ID]` is 1. The all-channels alias `0x1C8` always takes effect.
- R8: `rd_data` is combinational from `rd_addr`. Address `CH_BASE+0x08` returns `cyc_lo`, address `CH_BASE+0x18` returns `cyc_hi` in bits 3:0 with zeros in bits 15:4, and every other address returns zero. Writes to `CH_BASE+0x18` have no effect.
- R9: All snapshot outputs reset to zero and hold their values between strobes. Each `tic` replaces them, whether or not they were read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_inc | input | ACC_W | Accumulator increment per clock |
| tic | input | 1 | Measurement strobe: snapshot, then clear |
| test_mode | input | 1 | Enables counter preload writes |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 16 | Write data |
| chan_mask | input | NUM_CH | Channel select for the multi-channel alias |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 16 | Read data |
| cyc_hi | output | 4 | Snapshot of counter bits 19:16 |
| cyc_lo | output | 16 | Snapshot of counter bits 15:0 |
| phase_snap | output | PH_W | Snapshot of accumulator fraction |

## Verification
The hardest situations to reach are a carry landing exactly on a strobe and a count large enough to set the high bits.

For the first, the bench sets the increment to half the accumulator range, so the accumulator carries on every other cycle. It then asserts `tic` on two consecutive cycles, which makes exactly one of the two coincide with a carry. With the increment set to zero afterwards, the two following snapshots must sum to one.

For the high bits, the bench runs an all-ones increment for 66000 cycles, which gives close to one carry per clock and pushes the count past 2^16. The preload then has to clear those high bits.

// File: rtl/ccm_pkg.sv
package ccm_pkg;
  localparam int CNT_W = 20;
  localparam int LO_W  = 16;
  localparam int HI_W  = CNT_W - LO_W;

  typedef logic [CNT_W-1:0] cnt_t;

  // next counter value: preload beats strobe clear beats plain increment
  function automatic cnt_t cnt_next(cnt_t cur, logic ovf, logic tic,
                                    logic load, logic [LO_W-1:0] data);
    cnt_t r;
    if (load)     r = {{HI_W{1'b0}}, data};
    else if (tic) r = {{(CNT_W-1){1'b0}}, ovf};
    else          r = cur + {{(CNT_W-1){1'b0}}, ovf};
    return r;
  endfunction

  function automatic logic [HI_W-1:0] cnt_hi(cnt_t c);
    return c[CNT_W-1:LO_W];
  endfunction

  function automatic logic [LO_W-1:0] cnt_lo(cnt_t c);
    return c[LO_W-1:0];
  endfunction
endpackage

// File: rtl/ccm_phase_acc.sv
module ccm_phase_acc #(
  parameter int ACC_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] inc,
  output logic [ACC_W-1:0] acc_q,
  output logic             ovf
);
  function automatic logic [ACC_W:0] acc_step(logic [ACC_W-1:0] a,
                                               logic [ACC_W-1:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  logic [ACC_W:0] sum;

  always_comb sum = acc_step(acc_q, inc);
  assign ovf = sum[ACC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= sum[ACC_W-1:0];
  end
endmodule

// File: rtl/ccm_wr_decode.sv
module ccm_wr_decode #(
  parameter int ADDR_W     = 9,
  parameter int NUM_CH     = 12,
  parameter int CHAN_ID    = 3,
  parameter int CH_BASE    = 'h040,
  parameter int MULTI_BASE = 'h180,
  parameter int ALL_BASE   = 'h1C0
) (
  input  logic              wr_en,
  input  logic              test_mode,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [NUM_CH-1:0] chan_mask,
  output logic              cnt_load
);
  localparam int CNT_OFS = 'h08;
  localparam logic [ADDR_W-1:0] A_CH    = ADDR_W'(CH_BASE + CNT_OFS);
  localparam logic [ADDR_W-1:0] A_MULTI = ADDR_W'(MULTI_BASE + CNT_OFS);
  localparam logic [ADDR_W-1:0] A_ALL   = ADDR_W'(ALL_BASE + CNT_OFS);
  localparam logic [NUM_CH-1:0] MY_BIT  = NUM_CH'(1) << CHAN_ID;

  logic hit_ch, hit_multi, hit_all, selected;

  always_comb begin
    selected  = (chan_mask & MY_BIT) != '0;
    hit_ch    = (wr_addr == A_CH);
    hit_multi = (wr_addr == A_MULTI) && selected;
    hit_all   = (wr_addr == A_ALL);
    cnt_load  = wr_en && test_mode && (hit_ch || hit_multi || hit_all);
  end
endmodule

// File: rtl/ccm_cycle_cnt.sv
module ccm_cycle_cnt
  import ccm_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ovf,
  input  logic            tic,
  input  logic            load,
  input  logic [LO_W-1:0] load_data,
  output cnt_t            cnt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_next(cnt_q, ovf, tic, load, load_data);
  end
endmodule

// File: rtl/ccm_snapshot.sv
module ccm_snapshot
  import ccm_pkg::*;
#(
  parameter int ADDR_W  = 9,
  parameter int PH_W    = 8,
  parameter int CH_BASE = 'h040
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tic,
  input  cnt_t              cnt_q,
  input  logic [PH_W-1:0]   phase_in,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [HI_W-1:0]   cyc_hi,
  output logic [LO_W-1:0]   cyc_lo,
  output logic [PH_W-1:0]   phase_snap,
  output logic [LO_W-1:0]   rd_data
);
  localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(CH_BASE + 'h08);
  localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(CH_BASE + 'h18);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_hi     <= '0;
      cyc_lo     <= '0;
      phase_snap <= '0;
    end else if (tic) begin
      cyc_hi     <= cnt_hi(cnt_q);
      cyc_lo     <= cnt_lo(cnt_q);
      phase_snap <= phase_in;
    end
  end

  always_comb begin
    if (rd_addr == A_LO)      rd_data = cyc_lo;
    else if (rd_addr == A_HI) rd_data = {{(LO_W-HI_W){1'b0}}, cyc_hi};
    else                      rd_data = '0;
  end
endmodule

// File: rtl/carrier_cycle_meter.sv
module carrier_cycle_meter
  import ccm_pkg::*;
#(
  parameter int ACC_W      = 24,
  parameter int PH_W       = 8,
  parameter int ADDR_W     = 9,
  parameter int NUM_CH     = 12,
  parameter int CHAN_ID    = 3,
  parameter int CH_BASE    = 'h040,
  parameter int MULTI_BASE = 'h180,
  parameter int ALL_BASE   = 'h1C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ACC_W-1:0]  phase_inc,
  input  logic              tic,
  input  logic              test_mode,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [NUM_CH-1:0] chan_mask,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [15:0]       rd_data,
  output logic [3:0]        cyc_hi,
  output logic [15:0]       cyc_lo,
  output logic [PH_W-1:0]   phase_snap
);
  logic [ACC_W-1:0] acc_q;
  logic             acc_ovf;
  logic             cnt_load;
  cnt_t             cnt_q;
  logic [PH_W-1:0]  phase_frac;

  assign phase_frac = acc_q[ACC_W-1 -: PH_W];

  ccm_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .inc(phase_inc), .acc_q(acc_q), .ovf(acc_ovf)
  );

  ccm_wr_decode #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .CHAN_ID(CHAN_ID),
    .CH_BASE(CH_BASE), .MULTI_BASE(MULTI_BASE), .ALL_BASE(ALL_BASE)
  ) u_dec (
    .wr_en(wr_en), .test_mode(test_mode), .wr_addr(wr_addr),
    .chan_mask(chan_mask), .cnt_load(cnt_load)
  );

  ccm_cycle_cnt u_cnt (
    .clk(clk), .rst_n(rst_n), .ovf(acc_ovf), .tic(tic),
    .load(cnt_load), .load_data(wr_data), .cnt_q(cnt_q)
  );

  ccm_snapshot #(.ADDR_W(ADDR_W), .PH_W(PH_W), .CH_BASE(CH_BASE)) u_snap (
    .clk(clk), .rst_n(rst_n), .tic(tic), .cnt_q(cnt_q),
    .phase_in(phase_frac), .rd_addr(rd_addr), .cyc_hi(cyc_hi),
    .cyc_lo(cyc_lo), .phase_snap(phase_snap), .rd_data(rd_data)
  );
endmodule

// File: rtl/ccm_checker.sv
module ccm_checker #(
  parameter int PH_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            tic,
  input logic            test_mode,
  input logic [15:0]     wr_data,
  input logic            acc_ovf,
  input logic            cnt_load,
  input logic [19:0]     cnt_q,
  input logic [3:0]      cyc_hi,
  input logic [15:0]     cyc_lo,
  input logic [PH_W-1:0] phase_snap
);
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!tic && !cnt_load) |=> cnt_q == $past(cnt_q) + {19'd0, $past(acc_ovf)}); // R1

  AST_TIC_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    tic |=> {cyc_hi, cyc_lo} == $past(cnt_q)); // R2

  AST_TIC_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (tic && !cnt_load) |=> cnt_q == {19'd0, $past(acc_ovf)}); // R4

  AST_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> cnt_q == {4'd0, $past(wr_data)}); // R5

  AST_NO_LOAD_NORMAL: assert property (@(posedge clk) disable iff (!rst_n)
    !test_mode |-> !cnt_load); // R6

  AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !tic |=> ($stable(cyc_hi) && $stable(cyc_lo) && $stable(phase_snap))); // R9
endmodule

bind carrier_cycle_meter ccm_checker #(.PH_W(PH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tic(tic), .test_mode(test_mode),
  .wr_data(wr_data), .acc_ovf(acc_ovf), .cnt_load(cnt_load),
  .cnt_q(cnt_q), .cyc_hi(cyc_hi), .cyc_lo(cyc_lo), .phase_snap(phase_snap)
);

// File: tb/tb_carrier_cycle_meter.sv
`timescale 1ns/1ps
module tb_carrier_cycle_meter;
  localparam int ACC_W = 24;
  localparam int PH_W  = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic [ACC_W-1:0] phase_inc = '0;
  logic tic = 0, test_mode = 0, wr_en = 0;
  logic [8:0] wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0;
  logic [11:0] chan_mask = '0;
  logic [15:0] rd_data;
  logic [3:0] cyc_hi;
  logic [15:0] cyc_lo;
  logic [PH_W-1:0] phase_snap;

  int checks = 0, errors = 0;
  longint m_acc = 0, m_cnt = 0, m_hi = 0, m_lo = 0, m_ph = 0;
  longint a_val, b_val;

  carrier_cycle_meter dut (
    .clk(clk), .rst_n(rst_n), .phase_inc(phase_inc), .tic(tic),
    .test_mode(test_mode), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .chan_mask(chan_mask), .rd_addr(rd_addr),
    .rd_data(rd_data), .cyc_hi(cyc_hi), .cyc_lo(cyc_lo),
    .phase_snap(phase_snap)
  );

  always #2 clk = ~clk;

  task automatic check(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit addr_hits(logic [8:0] a, logic [11:0] m);
    return (a == 9'h048) || (a == 9'h188 && m[3]) || (a == 9'h1C8);
  endfunction

  function automatic longint model_rd(logic [8:0] a);
    if (a == 9'h048) return m_lo;
    if (a == 9'h058) return m_hi;
    return 0;
  endfunction

  // behavioural reference, updated on the same edge as the design
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_cnt = 0; m_hi = 0; m_lo = 0; m_ph = 0;
    end else begin
      longint s;
      bit c, ld;
      s  = m_acc + longint'(phase_inc);
      c  = (s >= (64'd1 << ACC_W));
      ld = wr_en && test_mode && addr_hits(wr_addr, chan_mask);
      if (tic) begin
        m_hi = m_cnt / 65536;
        m_lo = m_cnt % 65536;
        m_ph = m_acc / (64'd1 << (ACC_W - PH_W));
      end
      if (ld)       m_cnt = wr_data;
      else if (tic) m_cnt = c;
      else          m_cnt = (m_cnt + c) % (64'd1 << 20);
      m_acc = s % (64'd1 << ACC_W);
    end
  end

  // per-cycle comparison away from the edge
  always begin
    @(posedge clk);
    #1;
    if (rst_n) begin
      check("R2/R9 cyc_hi model", cyc_hi, m_hi);
      check("R1/R2 cyc_lo model", cyc_lo, m_lo);
      check("R3 phase_snap model", phase_snap, m_ph);
      check("R8 rd_data model", rd_data, model_rd(rd_addr));
    end
  end

  initial begin
    #(4 * 199000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_tic;
    tic = 1; cyc(1); tic = 0;
  endtask

  task automatic wr(logic [8:0] a, logic [15:0] d, logic [11:0] m);
    wr_en = 1; wr_addr = a; wr_data = d; chan_mask = m;
    cyc(1);
    wr_en = 0; chan_mask = '0;
  endtask

  initial begin
    cyc(2);
    check("R9 reset cyc_hi", cyc_hi, 0);
    check("R9 reset cyc_lo", cyc_lo, 0);
    check("R9 reset phase_snap", phase_snap, 0);
    rst_n = 1;
    cyc(1);

    // R1: counting at one carry per four clocks
    phase_inc = 24'h400000;
    pulse_tic();
    cyc(40);
    pulse_tic();
    check("R1 count over 41 clocks", cyc_lo, m_lo);
    check("R1 count near ten", (cyc_lo >= 10 && cyc_lo <= 11), 1);
    check("R3 phase fraction", phase_snap, m_ph);

    // R6: write ignored in normal mode
    phase_inc = '0;
    pulse_tic();
    wr(9'h048, 16'h7777, '0);
    pulse_tic();
    check("R6 normal-mode write ignored", cyc_lo, 0);

    // R5: preload in test mode
    test_mode = 1;
    wr(9'h048, 16'h1234, '0);
    pulse_tic();
    check("R5 preload low", cyc_lo, 16'h1234);
    check("R5 preload high", cyc_hi, 0);
    rd_addr = 9'h048; cyc(1);
    check("R8 read low", rd_data, 16'h1234);
    rd_addr = 9'h058; cyc(1);
    check("R8 read high", rd_data, 0);
    rd_addr = 9'h050; cyc(1);
    check("R8 unmapped read", rd_data, 0);

    // R8: write to snapshot address has no effect
    wr(9'h058, 16'h7777, '0);
    pulse_tic();
    check("R8 snapshot-address write ignored", cyc_lo, 0);

    // R7: aliases
    wr(9'h188, 16'h0ABC, ~12'h008);
    pulse_tic();
    check("R7 multi alias unselected", cyc_lo, 0);
    wr(9'h188, 16'h0ABC, 12'h008);
    pulse_tic();
    check("R7 multi alias selected", cyc_lo, 16'h0ABC);
    wr(9'h1C8, 16'h0321, '0);
    pulse_tic();
    check("R7 all-channels alias", cyc_lo, 16'h0321);

    // R5: write beats same-cycle strobe; strobe still snapshots old count
    wr_en = 1; wr_addr = 9'h048; wr_data = 16'h0042; tic = 1;
    cyc(1);
    wr_en = 0; tic = 0;
    check("R5 strobe snapshot before write", cyc_lo, 0);
    pulse_tic();
    check("R5 write wins over clear", cyc_lo, 16'h0042);
    test_mode = 0;

    // R2: high bits after a long run
    phase_inc = 24'hFFFFFF;
    pulse_tic();
    cyc(66000);
    phase_inc = '0;
    pulse_tic();
    check("R2 high bits set", cyc_hi, 1);
    rd_addr = 9'h058; cyc(1);
    check("R8 read high nonzero", rd_data, 1);

    // R5: preload clears high bits
    phase_inc = 24'hFFFFFF;
    cyc(66000);
    phase_inc = '0;
    test_mode = 1;
    wr(9'h048, 16'h0005, '0);
    test_mode = 0;
    pulse_tic();
    check("R5 preload zeros top bits", cyc_hi, 0);
    check("R5 preload value", cyc_lo, 5);

    // R4: carry coinciding with strobe
    phase_inc = 24'h800000;
    cyc(3);
    tic = 1; cyc(2); tic = 0;
    phase_inc = '0;
    a_val = cyc_lo;
    pulse_tic();
    b_val = cyc_lo;
    check("R4 coinciding carry counted once", a_val + b_val, 1);
    check("R9 replaced without read", cyc_lo, m_lo);

    cyc(2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule